// File: doc/BRIEF.md
# Read Port Select and Echo Strobe Control

This block sits beside the storage of a FIFO, on its read side. It takes a clocked chip-select, an asynchronous output enable, a read enable and the core's empty indication. From these it derives three things. The first is the enable that lets the data bus pads drive. The second is the pop qualifier handed to the FIFO core. The third is a registered echo strobe that tells a downstream receiver a fresh word left the FIFO in the previous read-clock cycle.

Chip-select reaches the bus only through a register, so it takes effect one read-clock edge later. The output enable overrides the bus at once, without a clock. While reset is held, the select input is ignored and the bus is driven whenever the output enable is low. That state lasts until the first read-clock edge after reset is released.

The select input does not gate the core's flags or its first-word fall-through. For that reason the block watches the read-enable guard rule. The rule says read enable must stay high for `GUARD_CYCLES` edges after the select becomes active. A sticky output reports any read attempted inside that window. The block has no data path of its own, so all of its pins are plain control and status signals with no valid/ready handshake.

Top module: `rdport_select`

## Requirements
- R1: While `rst_n` is low, `rd_pop` is 0, `echo_ren_n` is 1 and `guard_viol` is 0, and `bus_drive` equals the inverse of `oe_n` whatever `rcs_n` does, including across clock edges.
- R2: Once reset is released, `bus_drive` stays 1 (with `oe_n` low) until the first rising edge. After each rising edge it equals the inverse of the `rcs_n` value sampled at that edge, as long as `oe_n` is low.
- R3: `oe_n` high forces `bus_drive` to 0 at once, without waiting for a clock edge.
- R4: `rd_pop` is 1 exactly when `rst_n` is high and `rcs_n`, `ren_n` and `fifo_empty` are all 0. The pop is still issued when it breaks the guard rule.
- R5: `echo_ren_n` is 0 for the one cycle that follows each rising edge at which `rd_pop` was 1.
- R6: A rising edge with `rcs_n` high, `ren_n` high or `fifo_empty` high leaves `echo_ren_n` at 1 in the next cycle.
- R7: A rising edge is an activation edge when `rcs_n` is low and the registered select was inactive. A read attempt (`rcs_n` and `ren_n` both low) at an activation edge, or at any of the following `GUARD_CYCLES-1` edges while `rcs_n` stays low, sets `guard_viol` from the next cycle on. Only reset clears it.
- R8: Holding `ren_n` high at the activation edge and for the rest of the window leaves `guard_viol` at 0, and later reads proceed normally.
- R9: With `GUARD_CYCLES` = 2, a read attempt at the edge right after the activation edge sets `guard_viol`. With the default of 1 the same attempt does not set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rcs_n | input | 1 | Synchronous read chip-select, active low |
| ren_n | input | 1 | Read enable, active low |
| fifo_empty | input | 1 | Empty indication from the FIFO core, high when no word can be read |
| bus_drive | output | 1 | High when the data bus pads should drive |
| rd_pop | output | 1 | Pop qualifier to the FIFO core, sampled at the rising edge |
| echo_ren_n | output | 1 | Registered echo strobe, low for the cycle after a word was popped |
| guard_viol | output | 1 | Sticky flag, high after a read inside the post-select guard window |

## Verification
The bench targets the window right after reset. A design that loads the select register during reset, or resets it to inactive, would release the bus too early. The bench also changes `oe_n` between clock edges; a design that registers the override would show the bus still driven there. It drives read attempts with the FIFO empty and with the select inactive, where a loose qualifier would produce phantom pops and echo strobes. It also probes the edges on both sides of the guard window with two window lengths, which catches an off-by-one counter or a flag that clears itself.

// File: rtl/rdport_pkg.sv
package rdport_pkg;
  // Reset values of the registered outputs.
  localparam logic SEL_RST  = 1'b1;  // bus stays driven through reset
  localparam logic ECHO_IDLE = 1'b1; // echo strobe is active low

  // Read-side input sample, gathered once at the top.
  typedef struct packed {
    logic oe_n;
    logic rcs_n;
    logic ren_n;
    logic empty;
  } rd_inputs_t;

  function automatic logic read_attempt(input rd_inputs_t s);
    return !s.rcs_n && !s.ren_n;
  endfunction
endpackage

// File: rtl/rdport_sel_reg.sv
module rdport_sel_reg
  import rdport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rcs_n,
  output logic sel_q,
  output logic activate
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_RST;
    else        sel_q <= !rcs_n;
  end

  // This edge turns the registered select from inactive to active.
  assign activate = !sel_q && !rcs_n;
endmodule

// File: rtl/rdport_pop.sv
module rdport_pop
  import rdport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rd_inputs_t smp,
  output logic       pop,
  output logic       echo_n
);
  assign pop = rst_n && read_attempt(smp) && !smp.empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) echo_n <= ECHO_IDLE;
    else        echo_n <= !pop;
  end
endmodule

// File: rtl/rdport_guard.sv
module rdport_guard
  import rdport_pkg::*;
#(
  parameter int GUARD_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  rd_inputs_t smp,
  input  logic       activate,
  output logic       viol
);
  localparam int CW = (GUARD_CYCLES > 1) ? $clog2(GUARD_CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(GUARD_CYCLES - 1);

  logic [CW-1:0] left_q;
  logic          window;

  assign window = activate || ((left_q != '0) && !smp.rcs_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      viol   <= 1'b0;
    end else begin
      if (smp.rcs_n)          left_q <= '0;
      else if (activate)      left_q <= RELOAD;
      else if (left_q != '0)  left_q <= left_q - 1'b1;
      if (window && read_attempt(smp)) viol <= 1'b1;
    end
  end
endmodule

// File: rtl/rdport_select.sv
module rdport_select
  import rdport_pkg::*;
#(
  parameter int GUARD_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  input  logic rcs_n,
  input  logic ren_n,
  input  logic fifo_empty,
  output logic bus_drive,
  output logic rd_pop,
  output logic echo_ren_n,
  output logic guard_viol
);
  rd_inputs_t smp;
  logic       sel_q;
  logic       activate;

  assign smp = '{oe_n: oe_n, rcs_n: rcs_n, ren_n: ren_n, empty: fifo_empty};

  rdport_sel_reg u_sel (
    .clk(clk), .rst_n(rst_n), .rcs_n(rcs_n), .sel_q(sel_q), .activate(activate)
  );

  rdport_pop u_pop (
    .clk(clk), .rst_n(rst_n), .smp(smp), .pop(rd_pop), .echo_n(echo_ren_n)
  );

  rdport_guard #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
    .clk(clk), .rst_n(rst_n), .smp(smp), .activate(activate), .viol(guard_viol)
  );

  // Asynchronous override on top of the clocked select.
  assign bus_drive = !smp.oe_n && sel_q;
endmodule

// File: rtl/rdport_select_chk.sv
module rdport_select_chk (
  input logic clk,
  input logic rst_n,
  input logic oe_n,
  input logic rcs_n,
  input logic ren_n,
  input logic fifo_empty,
  input logic bus_drive,
  input logic rd_pop,
  input logic echo_ren_n,
  input logic guard_viol
);
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !bus_drive); // R3
  AST_BUS_FOLLOWS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !oe_n) |-> (bus_drive == !$past(rcs_n))); // R2
  AST_POP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> (!rcs_n && !ren_n && !fifo_empty)); // R4
  AST_ECHO_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |=> !echo_ren_n); // R5
  AST_ECHO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rcs_n || ren_n || fifo_empty) |=> echo_ren_n); // R6
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    guard_viol |=> guard_viol); // R7
endmodule

bind rdport_select rdport_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .rcs_n(rcs_n), .ren_n(ren_n),
  .fifo_empty(fifo_empty), .bus_drive(bus_drive), .rd_pop(rd_pop),
  .echo_ren_n(echo_ren_n), .guard_viol(guard_viol)
);

// File: tb/sim_rdport_select.sv
module sim_rdport_select;
  logic clk = 1'b0;
  logic rst_n, oe_n, rcs_n, ren_n, fifo_empty;
  logic bus_drive, rd_pop, echo_ren_n, guard_viol;
  logic bus1, pop1, echo1, viol1;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = !clk; // 125 MHz

  rdport_select u0 (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .rcs_n(rcs_n), .ren_n(ren_n),
    .fifo_empty(fifo_empty), .bus_drive(bus_drive), .rd_pop(rd_pop),
    .echo_ren_n(echo_ren_n), .guard_viol(guard_viol)
  );

  rdport_select #(.GUARD_CYCLES(2)) u1 (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .rcs_n(rcs_n), .ren_n(ren_n),
    .fifo_empty(fifo_empty), .bus_drive(bus1), .rd_pop(pop1),
    .echo_ren_n(echo1), .guard_viol(viol1)
  );

  // {oe_n, rcs_n, ren_n, empty, exp_pop, exp_drive_after_edge, exp_echo_after_edge}
  localparam logic [6:0] VEC [0:11] = '{
    7'b0110_001, 7'b0010_011, 7'b0000_110, 7'b0001_011,
    7'b0000_110, 7'b1000_100, 7'b1010_001, 7'b0100_001,
    7'b0111_001, 7'b0011_011, 7'b0000_110, 7'b1110_001
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #40000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; oe_n = 0; rcs_n = 0; ren_n = 0; fifo_empty = 0;
    @(negedge clk); @(negedge clk);
    // R1 / R4: quiet outputs in reset even with a would-be read
    chk(bus_drive, 1'b1, "R1 drive in reset");
    chk(echo_ren_n, 1'b1, "R1 echo in reset");
    chk(guard_viol, 1'b0, "R1 viol in reset");
    chk(rd_pop, 1'b0, "R4 no pop in reset");
    rcs_n = 1;
    @(posedge clk); #1;
    chk(bus_drive, 1'b1, "R1 rcs_n ignored in reset");
    oe_n = 1; #1;
    chk(bus_drive, 1'b0, "R3 async release in reset");
    oe_n = 0; #1;
    chk(bus_drive, 1'b1, "R1 oe_n low drives in reset");

    // R2: release reset with rcs_n high
    @(negedge clk);
    ren_n = 1; rst_n = 1; #1;
    chk(bus_drive, 1'b1, "R2 driven until first edge");
    @(posedge clk); #1;
    chk(bus_drive, 1'b0, "R2 first edge follows rcs_n");

    // table walk
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      {oe_n, rcs_n, ren_n, fifo_empty} = VEC[i][6:3];
      #1;
      chk(rd_pop, VEC[i][2], $sformatf("R4 pop vec %0d", i));
      @(posedge clk); #1;
      chk(bus_drive, VEC[i][1], $sformatf("R2 drive vec %0d", i));
      chk(echo_ren_n, VEC[i][0], $sformatf("R5 echo vec %0d", i));
    end
    chk(guard_viol, 1'b0, "R8 no violation over table");

    // R3: mid-cycle override with select active
    @(negedge clk);
    oe_n = 0; rcs_n = 0; ren_n = 1; fifo_empty = 0;
    @(posedge clk); #1;
    chk(bus_drive, 1'b1, "R2 selected");
    #1 oe_n = 1; #1;
    chk(bus_drive, 1'b0, "R3 override without clock");
    @(negedge clk);
    oe_n = 0; rcs_n = 1; ren_n = 1;
    @(posedge clk); #1;
    chk(echo_ren_n, 1'b1, "R6 rcs_n high gives no echo");

    // R7: read at the activation edge
    @(negedge clk);
    rcs_n = 0; ren_n = 0; fifo_empty = 0; #1;
    chk(rd_pop, 1'b1, "R4 pop not blocked by guard");
    @(posedge clk); #1;
    chk(guard_viol, 1'b1, "R7 violation set");
    chk(echo_ren_n, 1'b0, "R5 echo on guarded pop");
    @(negedge clk);
    rcs_n = 1; ren_n = 1;
    @(posedge clk); #1;
    chk(guard_viol, 1'b1, "R7 violation sticky");
    @(negedge clk);
    rst_n = 0; #1;
    chk(guard_viol, 1'b0, "R1 reset clears violation");
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;

    // R8 / R9: read one edge after activation
    @(negedge clk);
    rcs_n = 0; ren_n = 1;
    @(posedge clk); #1;
    chk(guard_viol, 1'b0, "R8 activation with ren_n high");
    @(negedge clk);
    ren_n = 0;
    @(posedge clk); #1;
    chk(guard_viol, 1'b0, "R8 read after one-cycle window");
    chk(viol1, 1'b1, "R9 two-cycle window catches read");
    chk(echo_ren_n, 1'b0, "R8 read proceeds");
    @(negedge clk);
    @(posedge clk); #1;
    chk(guard_viol, 1'b0, "R8 continued reads clean");
    chk(viol1, 1'b1, "R9 sticky in wide window");

    done = 1;
    finish_run();
  end
endmodule